// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a 32-bit in-order core into an exception handler. The core presents up to seven request lines, one for each exception number from 1 to 7, together with the PC of the instruction being interrupted. The block selects one request, works out the handler address from a 256-byte-aligned base register plus a 32-byte slot per exception number, and for one cycle tells the core to load that address, to write the interrupted PC into one of two link registers, and it updates its interrupt-enable status bits.

Exceptions fall into two classes. Breakpoint (1) and watchpoint (3) are debug exceptions: they always vector from the debug base, save the PC in the breakpoint-address link register and save the global enable into the saved-breakpoint-enable bit. All others are ordinary exceptions: they vector from the normal base, or from the debug base when the remap input is high, and they use the exception-address link register and the saved-exception-enable bit. The core's register-write path can load the three status bits directly.

The controller has two states. `ST_IDLE` waits for a request. Transition `T_ACCEPT` (IDLE to COMMIT) fires on a clock edge where an eligible request is present. `ST_COMMIT` drives the load and link-write strobes for exactly one cycle. Transition `T_RETIRE` (COMMIT to IDLE) is unconditional.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Exception numbers are 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 external interrupt, 7 system call; request bit k of `exc_req` raises number k. The handler address is the selected base with its low 8 bits replaced by the exception number times 32, so `next_pc[4:0]` is always zero.
- R2: Ordinary exceptions (2, 4, 5, 6, 7) vector from `norm_base`, or from `dbg_base` when `remap_dbg` is 1 in the accept cycle.
- R3: Debug exceptions (1, 3) vector from `dbg_base` whatever `remap_dbg` holds.
- R4: During the commit cycle `lr_we` is 1 and `lr_data` equals `cur_pc` from the accept cycle; `lr_sel` is 0 (exception-address register) for ordinary exceptions and 1 (breakpoint-address register) for debug exceptions.
- R5: On entry `gie` becomes 0. An ordinary exception sets `seie` if `gie` was 1; a debug exception sets `sbie` if `gie` was 1. A saved bit is never cleared on entry, and the other class's saved bit is unchanged.
- R6: An external interrupt request is accepted only while `gie` is 1; a masked interrupt produces no `pc_load`.
- R7: When several eligible requests are present together, the lowest exception number is taken; the others are dropped, not remembered.
- R8: A request sampled on a rising edge in `ST_IDLE` makes `pc_load` high for exactly the next cycle; requests present during `ST_COMMIT` are ignored.
- R9: `stat_wr_en` loads `{sbie, seie, gie}` from `stat_wr_data[2:0]` on the next edge, unless an exception is accepted on that edge, in which case the entry update wins.
- R10: After reset the block is in `ST_IDLE`, all strobes are 0 and `gie`, `seie`, `sbie` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Request lines, bit k raises exception number k (bits 7..1) |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| norm_base | input | 32 | Normal handler base, low 8 bits ignored |
| dbg_base | input | 32 | Debug handler base, low 8 bits ignored |
| remap_dbg | input | 1 | Send ordinary exceptions to the debug base |
| stat_wr_en | input | 1 | Load the status bits |
| stat_wr_data | input | 3 | New `{sbie, seie, gie}` |
| pc_load | output | 1 | Load `next_pc` into the PC this cycle |
| next_pc | output | 32 | Handler address |
| lr_we | output | 1 | Link-register write strobe |
| lr_sel | output | 1 | 0 exception-address register, 1 breakpoint-address register |
| lr_data | output | 32 | Saved return PC |
| gie | output | 1 | Global interrupt enable |
| seie | output | 1 | Saved enable for ordinary exceptions |
| sbie | output | 1 | Saved enable for debug exceptions |

## Verification
The bench goes after simultaneous requests, where a reversed or incomplete priority encoder would vector to the wrong slot or replay a dropped request one cycle later. It raises an interrupt with the global enable clear, alone and together with a system call, so a missing mask either takes the interrupt or hides the system call. It toggles the remap bit under both classes, catching a design that remaps debug exceptions or ignores remap, and it enters with the enable clear to catch saved bits that are overwritten instead of only set. It also drives a new request during the commit cycle and a status write on an accept edge, which expose a state machine that re-accepts early or a status path with the wrong precedence.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int EXC_COUNT  = 8;
    localparam int NUM_W      = $clog2(EXC_COUNT);
    localparam int SLOT_SHIFT = 5;
    localparam int VEC_LSB    = NUM_W + SLOT_SHIFT;

    typedef enum logic [NUM_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_BREAK = 3'd1,
        EXC_IBUS  = 3'd2,
        EXC_WATCH = 3'd3,
        EXC_DBUS  = 3'd4,
        EXC_DIV   = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_SCALL = 3'd7
    } exc_num_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } entry_state_e;

    function automatic logic is_debug(exc_num_e n);
        return (n == EXC_BREAK) || (n == EXC_WATCH);
    endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_entry_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EXC_COUNT-1:1]   req_i,
    input  logic                   gie_i,
    output logic                   hit_o,
    output exc_num_e               num_o
);

    logic [EXC_COUNT-1:1] eligible;

    // Only the interrupt line is gated by the global enable.
    for (genvar gi = 1; gi < EXC_COUNT; gi++) begin : g_mask
        if (gi == int'(EXC_IRQ)) begin : g_irq
            assign eligible[gi] = req_i[gi] & gie_i;
        end else begin : g_plain
            assign eligible[gi] = req_i[gi];
        end
    end

    // Scan from the top down so the lowest number overwrites last.
    always_comb begin
        hit_o = 1'b0;
        num_o = EXC_RESET;
        for (int k = EXC_COUNT - 1; k >= 1; k--) begin
            if (eligible[k]) begin
                hit_o = 1'b1;
                num_o = exc_num_e'(k[NUM_W-1:0]);
            end
        end
    end

    // R7: the chosen number is one that was actually requested
    a_r7_hit_requested: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> req_i[num_o]);

    // R6: an interrupt is never picked while globally disabled
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && num_o == EXC_IRQ) |-> gie_i);

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] norm_base_i,
    input  logic [XLEN-1:0] dbg_base_i,
    input  logic            remap_i,
    input  exc_num_e        num_i,
    output logic [XLEN-1:0] vec_o
);

    logic            use_dbg;
    logic [XLEN-1:0] base_sel;
    logic            unused_low;

    assign use_dbg    = is_debug(num_i) | remap_i;
    assign base_sel   = use_dbg ? dbg_base_i : norm_base_i;
    assign vec_o      = {base_sel[XLEN-1:VEC_LSB], num_i, {SLOT_SHIFT{1'b0}}};
    assign unused_low = ^{norm_base_i[VEC_LSB-1:0], dbg_base_i[VEC_LSB-1:0]};

endmodule

// File: rtl/exc_status.sv
module exc_status
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       is_dbg_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_data_i,
    output logic       gie_o,
    output logic       seie_o,
    output logic       sbie_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o  <= 1'b0;
            seie_o <= 1'b0;
            sbie_o <= 1'b0;
        end else if (accept_i) begin
            gie_o <= 1'b0;
            if (is_dbg_i) begin
                sbie_o <= sbie_o | gie_o;
            end else begin
                seie_o <= seie_o | gie_o;
            end
        end else if (wr_en_i) begin
            {sbie_o, seie_o, gie_o} <= wr_data_i;
        end
    end

    // R5: entry always leaves interrupts disabled
    a_r5_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !gie_o);

    // R5: saved bits capture an enabled state
    a_r5_seie_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !is_dbg_i && gie_o) |=> seie_o);

    a_r5_sbie_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && is_dbg_i && gie_o) |=> sbie_o);

    // R5: saved bits only drop through an explicit write
    a_r5_seie_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seie_o) |-> $past(wr_en_i) && !$past(accept_i));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EXC_COUNT-1:1] exc_req,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic [XLEN-1:0]      norm_base,
    input  logic [XLEN-1:0]      dbg_base,
    input  logic                 remap_dbg,
    input  logic                 stat_wr_en,
    input  logic [2:0]           stat_wr_data,
    output logic                 pc_load,
    output logic [XLEN-1:0]      next_pc,
    output logic                 lr_we,
    output logic                 lr_sel,
    output logic [XLEN-1:0]      lr_data,
    output logic                 gie,
    output logic                 seie,
    output logic                 sbie
);

    entry_state_e    state, state_nx;
    logic            hit, accept;
    exc_num_e        sel_num, cap_num;
    logic [XLEN-1:0] sel_vec, cap_vec, cap_pc;

    exc_prio_sel u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (exc_req),
        .gie_i (gie),
        .hit_o (hit),
        .num_o (sel_num)
    );

    exc_vec_calc #(.XLEN(XLEN)) u_vec (
        .norm_base_i (norm_base),
        .dbg_base_i  (dbg_base),
        .remap_i     (remap_dbg),
        .num_i       (sel_num),
        .vec_o       (sel_vec)
    );

    exc_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .is_dbg_i  (is_debug(sel_num)),
        .wr_en_i   (stat_wr_en),
        .wr_data_i (stat_wr_data),
        .gie_o     (gie),
        .seie_o    (seie),
        .sbie_o    (sbie)
    );

    assign accept = (state == ST_IDLE) && hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = hit ? ST_COMMIT : ST_IDLE;   // T_ACCEPT
            ST_COMMIT: state_nx = ST_IDLE;                     // T_RETIRE
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_num <= EXC_RESET;
            cap_vec <= '0;
            cap_pc  <= '0;
        end else if (accept) begin
            cap_num <= sel_num;
            cap_vec <= sel_vec;
            cap_pc  <= cur_pc;
        end
    end

    always_comb begin
        pc_load = 1'b0;
        lr_we   = 1'b0;
        lr_sel  = 1'b0;
        next_pc = '0;
        lr_data = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_COMMIT: begin
                pc_load = 1'b1;
                lr_we   = 1'b1;
                lr_sel  = is_debug(cap_num);
                next_pc = cap_vec;
                lr_data = cap_pc;
            end
            default: begin
            end
        endcase
    end

    // R8: the load strobe is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    // R1: handler addresses sit on 32-byte slots
    a_r1_slot_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> next_pc[SLOT_SHIFT-1:0] == '0);

    // R4: the link write carries the PC seen on the accept edge
    a_r4_link_pc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> lr_we && lr_data == $past(cur_pc));

    // R3: debug entries use the debug base
    a_r3_debug_base: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && lr_sel) |-> next_pc[XLEN-1:VEC_LSB] == $past(dbg_base[XLEN-1:VEC_LSB]));

    // R2: ordinary entries without remap use the normal base
    a_r2_normal_base: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !lr_sel && !$past(remap_dbg)) |->
            next_pc[XLEN-1:VEC_LSB] == $past(norm_base[XLEN-1:VEC_LSB]));

endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

    localparam int XLEN = 32;

    typedef struct {
        logic [XLEN-1:0] pc;
        logic            sel;
        logic [XLEN-1:0] lr;
        logic [2:0]      stat;
        string           tag;
    } exp_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:1]      exc_req = '0;
    logic [XLEN-1:0] cur_pc = '0;
    logic [XLEN-1:0] norm_base = 32'h0000_1A55;
    logic [XLEN-1:0] dbg_base  = 32'hFFFF_80C3;
    logic            remap_dbg = 1'b0;
    logic            stat_wr_en = 1'b0;
    logic [2:0]      stat_wr_data = '0;
    logic            pc_load, lr_we, lr_sel, gie, seie, sbie;
    logic [XLEN-1:0] next_pc, lr_data;

    exp_item_t sb_q[$];
    int        n_checks = 0;
    int        n_fail   = 0;
    logic      m_gie = 0, m_seie = 0, m_sbie = 0;

    exc_entry_ctrl #(.XLEN(XLEN)) u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
        .norm_base(norm_base), .dbg_base(dbg_base), .remap_dbg(remap_dbg),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .pc_load(pc_load), .next_pc(next_pc), .lr_we(lr_we), .lr_sel(lr_sel),
        .lr_data(lr_data), .gie(gie), .seie(seie), .sbie(sbie)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected item on every commit cycle.
    always @(negedge clk) begin
        if (rst_n && pc_load) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected pc_load", {{(XLEN-32){1'b0}}, next_pc}, '0);
            end else begin
                exp_item_t e;
                e = sb_q.pop_front();
                check(next_pc == e.pc, {e.tag, " R1 next_pc"}, next_pc, e.pc);
                check(lr_we && lr_sel == e.sel && lr_data == e.lr,
                      {e.tag, " R4 link"}, {lr_sel, lr_data[XLEN-2:0]}, {e.sel, e.lr[XLEN-2:0]});
                check({sbie, seie, gie} == e.stat, {e.tag, " R5 status"},
                      XLEN'({sbie, seie, gie}), XLEN'(e.stat));
            end
        end
    end

    // Driver: apply one cycle of stimulus, predict and queue the result.
    task automatic fire(input logic [7:1] reqs, input logic [XLEN-1:0] pc,
                        input logic wr, input logic [2:0] wd, input string tag);
        logic [7:1]      elig;
        int              num;
        logic            dbg;
        logic [XLEN-1:0] base;
        exp_item_t       e;
        @(negedge clk);
        exc_req = reqs; cur_pc = pc; stat_wr_en = wr; stat_wr_data = wd;
        elig = reqs;
        elig[6] = reqs[6] & m_gie;
        num = 0;
        for (int k = 7; k >= 1; k--) if (elig[k]) num = k;
        if (num != 0) begin
            dbg  = (num == 1) || (num == 3);
            base = (dbg || remap_dbg) ? dbg_base : norm_base;
            if (dbg) m_sbie = m_sbie | m_gie;
            else     m_seie = m_seie | m_gie;
            m_gie = 1'b0;
            e.pc = {base[XLEN-1:8], num[2:0], 5'b0};
            e.sel = dbg;
            e.lr = pc;
            e.stat = {m_sbie, m_seie, m_gie};
            e.tag = tag;
            sb_q.push_back(e);
        end else if (wr) begin
            {m_sbie, m_seie, m_gie} = wd;
        end
        @(posedge clk);
        @(negedge clk);
        exc_req = '0; stat_wr_en = 1'b0;
        if (num == 0) begin
            check(!pc_load, {tag, " no entry"}, XLEN'(pc_load), '0);
            check({sbie, seie, gie} == {m_sbie, m_seie, m_gie}, {tag, " status"},
                  XLEN'({sbie, seie, gie}), XLEN'({m_sbie, m_seie, m_gie}));
        end
        @(negedge clk);
        check(!pc_load, {tag, " R7 no replay"}, XLEN'(pc_load), '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pc_load && !lr_we && {sbie, seie, gie} == 3'b000, "R10 reset",
              XLEN'({pc_load, lr_we, sbie, seie, gie}), '0);
        rst_n = 1'b1;

        fire(7'b0000000, 32'h0, 1'b1, 3'b001, "R9 set gie");
        fire(7'b1000000, 32'h0000_0100, 1'b0, 3'b000, "R2 syscall normal base");
        fire(7'b0100000, 32'h0000_0104, 1'b0, 3'b000, "R6 masked irq");
        fire(7'b0000000, 32'h0, 1'b1, 3'b001, "R9 reenable");
        fire(7'b0100000, 32'h0000_0108, 1'b0, 3'b000, "R6 irq accepted");
        remap_dbg = 1'b1;
        fire(7'b0000000, 32'h0, 1'b1, 3'b011, "R9 write");
        fire(7'b0010000, 32'h0000_2000, 1'b0, 3'b000, "R2 remapped div");
        fire(7'b0000000, 32'h0, 1'b1, 3'b001, "R9 reenable");
        remap_dbg = 1'b0;
        fire(7'b0000001, 32'h0000_2004, 1'b0, 3'b000, "R3 breakpoint");
        fire(7'b0000100, 32'h0000_2008, 1'b0, 3'b000, "R5 watch sticky sbie");
        remap_dbg = 1'b1;
        fire(7'b0000100, 32'h0000_200C, 1'b0, 3'b000, "R3 watch ignores remap");
        remap_dbg = 1'b0;
        fire(7'b0000000, 32'h0, 1'b1, 3'b001, "R9 clear saved");
        fire(7'b0010001, 32'h0000_3000, 1'b0, 3'b000, "R7 bp over div");
        fire(7'b1111111, 32'h0000_3004, 1'b0, 3'b000, "R7 all requests");
        fire(7'b0001010, 32'h0000_3008, 1'b0, 3'b000, "R7 ibus over dbus");
        fire(7'b1101000, 32'h0000_300C, 1'b0, 3'b000, "R7 dbus over irq");
        fire(7'b1100000, 32'h0000_3010, 1'b0, 3'b000, "R6 masked irq yields syscall");
        fire(7'b0000000, 32'h0, 1'b1, 3'b001, "R9 reenable");
        fire(7'b0000010, 32'h0000_4000, 1'b1, 3'b111, "R9 accept beats write");

        // R8: a request during the commit cycle is ignored.
        begin
            exp_item_t e;
            @(negedge clk);
            exc_req = 7'b0010000; cur_pc = 32'h0000_5000;
            e.pc = {norm_base[XLEN-1:8], 3'd5, 5'b0};
            e.sel = 1'b0; e.lr = 32'h0000_5000;
            e.stat = {m_sbie, m_seie, 1'b0}; e.tag = "R8 commit";
            sb_q.push_back(e);
            @(negedge clk);
            exc_req = 7'b0000001;
            @(negedge clk);
            exc_req = '0;
            check(!pc_load, "R8 commit-cycle request ignored", XLEN'(pc_load), '0);
        end

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R8 all entries seen", XLEN'(sb_q.size()), '0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule